// File: doc/BRIEF.md
# LCD Initialisation Script Sequencer

This block replays a byte-coded start-up script, held in a small synchronous ROM, onto an 8080-style parallel panel bus. A start pulse begins the run. The block then fetches script bytes in ascending address order and works out the role of each byte as it arrives: a header, a command, a data byte or a delay count. Commands and data go out as bus writes, each with its own write strobe. A delay count pauses the run for the given number of pulses on a millisecond tick input.

Each header byte uses three fields. Bit 6 set means a command byte comes next. Bits 5:0 give how many data bytes follow. Bit 7 set means a delay byte closes the entry. The run ends as soon as the byte address equals the script length supplied at the port. This holds even when that length cuts the last entry short. Chip select is held active for the whole run, and a one-cycle done pulse marks the end.

Top module: `lcd_script_player`

## Requirements
- R1: In a header byte, bit 6 set announces a command byte, bit 7 set announces a trailing delay byte, and bits 5:0 give the number of data bytes. A header with no flags and a count of zero is consumed and produces no write.
- R2: Within one entry, the command byte (if flagged) is written first, then the data bytes in script order, and the delay byte (if flagged) is taken last.
- R3: A delay byte never reaches the bus. It stalls the sequencer until that many `tick_ms_i` pulses have been seen, and a delay of zero stalls for none.
- R4: Each command byte is written with `bus_rs_o` low and each data byte with `bus_rs_o` high. The byte sits on bits 7:0 of `bus_data_o` and the upper bits are zero. `bus_wr_n_o` stays low for exactly WR_LO_CYC cycles with data and RS held steady, then stays high for at least WR_HI_CYC cycles before the next write.
- R5: `bus_cs_n_o` goes low when a run starts, stays low across every write, and is high again in the cycle `done_o` is asserted and while idle.
- R6: The run ends when the byte address reaches `script_len_i`, even if the final entry is incomplete. A length of zero finishes with no write.
- R7: A header with no flags and a nonzero count sends only data bytes. A header with only the command flag sends a bare command.
- R8: Each byte is requested by one `rom_rd_o` cycle with its address on `rom_addr_o`, and it is taken from `rom_data_i` on the next cycle. Every address below the length is read exactly once.
- R9: `done_o` is high for exactly one cycle per run. A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to play the script |
| script_len_i | input | ADDR_W | Number of script bytes |
| rom_rd_o | output | 1 | ROM read request |
| rom_addr_o | output | ADDR_W | ROM byte address |
| rom_data_i | input | 8 | ROM read data, valid one cycle after the request |
| tick_ms_i | input | 1 | Millisecond tick pulse used for delays |
| bus_data_o | output | DATA_W | Panel bus data word |
| bus_rs_o | output | 1 | Register select: 0 for command, 1 for data |
| bus_wr_n_o | output | 1 | Active-low write strobe |
| bus_cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The scripts used mix every header shape. One entry has both flags and data, one has a delay but no command, data-only entries are present, a bare command appears, and an empty header is skipped. A delay of zero is included to show it does not hang the run, while a manual tick test with delay three shows that exactly the third tick releases the next write and that a start during that stall has no effect. A length that cuts an entry mid-way, a length shorter than the stored bytes, and a length of zero separate the end-of-script test from the header decode. Write order and RS level tell a command from a data byte, and the read count shows that no byte is fetched twice.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   localparam int HDR_CMD_BIT = 6;
   localparam int HDR_DLY_BIT = 7;
   localparam int HDR_CNT_W   = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NEXT,
      ST_WAIT,
      ST_STROBE,
      ST_DELAY,
      ST_FINISH
   } seq_state_t;

   typedef struct packed {
      logic                 has_dly;
      logic                 has_cmd;
      logic [HDR_CNT_W-1:0] count;
   } hdr_t;

   function automatic hdr_t decode_hdr(input logic [7:0] b);
      hdr_t h;
      h.has_dly = b[HDR_DLY_BIT];
      h.has_cmd = b[HDR_CMD_BIT];
      h.count   = b[HDR_CNT_W-1:0];
      return h;
   endfunction

endpackage

// File: rtl/lcd_byte_cursor.sv
module lcd_byte_cursor #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   input  logic [ADDR_W-1:0] limit,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("lcd_byte_cursor: ADDR_W must be at least 1");
   end

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (clr) begin
         addr_q <= '0;
      end else if (inc) begin
         addr_q <= addr_q + ADDR_W'(1);
      end
   end

   assign addr   = addr_q;
   assign at_end = (addr_q >= limit);

   // R8: the address only advances while it is below the limit
   p_inc_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (addr_q < limit));

endmodule

// File: rtl/lcd_wr_strobe.sv
module lcd_wr_strobe #(
   parameter int LO_CYC = 2,
   parameter int HI_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic wr_n,
   output logic fin
);

   localparam int MAX_CYC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (LO_CYC < 1) begin : g_bad_lo
      $error("lcd_wr_strobe: LO_CYC must be at least 1");
   end
   if (HI_CYC < 1) begin : g_bad_hi
      $error("lcd_wr_strobe: HI_CYC must be at least 1");
   end

   typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} phase_t;

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             lo_last;
   logic             hi_last;

   assign lo_last = (cnt_q == CNT_W'(LO_CYC - 1));
   assign hi_last = (cnt_q == CNT_W'(HI_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (go) begin
                  phase_q <= PH_LO;
                  cnt_q   <= '0;
               end
            end
            PH_LO: begin
               if (lo_last) begin
                  phase_q <= PH_HI;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            PH_HI: begin
               if (hi_last) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign wr_n = (phase_q != PH_LO);
   assign fin  = (phase_q == PH_HI) && hi_last;

   // R4: a new strobe is never requested while one is in flight
   p_go_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (phase_q == PH_IDLE));

   // R4: the strobe always follows a request in the next cycle
   p_go_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !wr_n);

endmodule

// File: rtl/lcd_tick_delay.sv
module lcd_tick_delay #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   input  logic             tick,
   output logic             zero
);

   if (CNT_W < 1) begin : g_bad_w
      $error("lcd_tick_delay: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= value;
      end else if (tick && (left_q != '0)) begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign zero = (left_q == '0);

   // R3: the remaining count only moves on a tick or a fresh load
   p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(left_q));

endmodule

// File: rtl/lcd_script_player.sv
module lcd_script_player #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 8,
   parameter int WR_LO_CYC = 2,
   parameter int WR_HI_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] script_len_i,
   output logic              rom_rd_o,
   output logic [ADDR_W-1:0] rom_addr_o,
   input  logic [7:0]        rom_data_i,
   input  logic              tick_ms_i,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_rs_o,
   output logic              bus_wr_n_o,
   output logic              bus_cs_n_o,
   output logic              done_o
);
   import lcd_seq_pkg::*;

   localparam int BYTE_W = 8;
   localparam int PAD_W  = DATA_W - BYTE_W;

   if (DATA_W < BYTE_W) begin : g_bad_data_w
      $error("lcd_script_player: DATA_W must be at least 8");
   end

   seq_state_t           state_q;
   logic                 pend_cmd_q;
   logic                 pend_dly_q;
   logic [HDR_CNT_W-1:0] data_left_q;
   logic [BYTE_W-1:0]    byte_q;
   logic                 rs_q;
   logic                 cs_n_q;

   logic                 at_end;
   logic                 cur_clr;
   logic                 cur_inc;
   logic                 strobe_go;
   logic                 strobe_fin;
   logic                 dly_load;
   logic                 dly_zero;
   logic                 in_wait;
   hdr_t                 hdr;

   assign in_wait   = (state_q == ST_WAIT);
   assign hdr       = decode_hdr(rom_data_i);
   assign cur_clr   = (state_q == ST_IDLE) && start_i;
   assign cur_inc   = in_wait;
   assign strobe_go = in_wait && (pend_cmd_q || (data_left_q != '0));
   assign dly_load  = in_wait && !pend_cmd_q && (data_left_q == '0) && pend_dly_q;
   assign rom_rd_o  = (state_q == ST_NEXT) && !at_end;

   lcd_byte_cursor #(
      .ADDR_W (ADDR_W)
   ) u_cursor (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cur_clr),
      .inc    (cur_inc),
      .limit  (script_len_i),
      .addr   (rom_addr_o),
      .at_end (at_end)
   );

   lcd_wr_strobe #(
      .LO_CYC (WR_LO_CYC),
      .HI_CYC (WR_HI_CYC)
   ) u_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (strobe_go),
      .wr_n  (bus_wr_n_o),
      .fin   (strobe_fin)
   );

   lcd_tick_delay #(
      .CNT_W (BYTE_W)
   ) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (dly_load),
      .value (rom_data_i),
      .tick  (tick_ms_i),
      .zero  (dly_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_cmd_q  <= 1'b0;
         pend_dly_q  <= 1'b0;
         data_left_q <= '0;
         byte_q      <= '0;
         rs_q        <= 1'b0;
         cs_n_q      <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q     <= ST_NEXT;
                  cs_n_q      <= 1'b0;
                  pend_cmd_q  <= 1'b0;
                  pend_dly_q  <= 1'b0;
                  data_left_q <= '0;
               end
            end
            ST_NEXT: begin
               if (at_end) begin
                  state_q <= ST_FINISH;
                  cs_n_q  <= 1'b1;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (pend_cmd_q) begin
                  byte_q     <= rom_data_i;
                  rs_q       <= 1'b0;
                  pend_cmd_q <= 1'b0;
                  state_q    <= ST_STROBE;
               end else if (data_left_q != '0) begin
                  byte_q      <= rom_data_i;
                  rs_q        <= 1'b1;
                  data_left_q <= data_left_q - HDR_CNT_W'(1);
                  state_q     <= ST_STROBE;
               end else if (pend_dly_q) begin
                  pend_dly_q <= 1'b0;
                  state_q    <= ST_DELAY;
               end else begin
                  pend_cmd_q  <= hdr.has_cmd;
                  pend_dly_q  <= hdr.has_dly;
                  data_left_q <= hdr.count;
                  state_q     <= ST_NEXT;
               end
            end
            ST_STROBE: begin
               if (strobe_fin) begin
                  state_q <= ST_NEXT;
               end
            end
            ST_DELAY: begin
               if (dly_zero) begin
                  state_q <= ST_NEXT;
               end
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
               cs_n_q  <= 1'b1;
            end
         endcase
      end
   end

   if (PAD_W == 0) begin : g_bus_exact
      assign bus_data_o = byte_q;
   end else begin : g_bus_padded
      assign bus_data_o = {{PAD_W{1'b0}}, byte_q};
   end

   assign bus_rs_o   = rs_q;
   assign bus_cs_n_o = cs_n_q;
   assign done_o     = (state_q == ST_FINISH);

   // R5: no write strobe without chip select
   p_wr_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n_o |-> !bus_cs_n_o);

   // R5: chip select is released by the time done is flagged
   p_cs_free_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> bus_cs_n_o);

   // R4: data and RS stay steady while the strobe is low
   p_bus_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr_n_o && $past(!bus_wr_n_o)) |-> ($stable(bus_data_o) && $stable(bus_rs_o)));

   // R9: done lasts a single cycle
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: done only once the whole script has been addressed
   p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rom_addr_o >= script_len_i));

   // R3: no write begins during a delay stall
   p_quiet_in_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELAY) |-> bus_wr_n_o);

   // R8: a read is never issued past the script length
   p_read_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd_o |-> (rom_addr_o < script_len_i));

endmodule

// File: tb/lcd_script_player_test.sv
`timescale 1ns/1ps
module lcd_script_player_test;

   localparam int DATA_W    = 16;
   localparam int ADDR_W    = 8;
   localparam int WR_LO_CYC = 3;
   localparam int WR_HI_CYC = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic [ADDR_W-1:0] script_len_i;
   logic              rom_rd_o;
   logic [ADDR_W-1:0] rom_addr_o;
   logic [7:0]        rom_q;
   logic              tick_ms_i;
   logic [DATA_W-1:0] bus_data_o;
   logic              bus_rs_o;
   logic              bus_wr_n_o;
   logic              bus_cs_n_o;
   logic              done_o;

   always #2 clk = ~clk;

   lcd_script_player #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .WR_LO_CYC (WR_LO_CYC),
      .WR_HI_CYC (WR_HI_CYC)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .script_len_i (script_len_i),
      .rom_rd_o     (rom_rd_o),
      .rom_addr_o   (rom_addr_o),
      .rom_data_i   (rom_q),
      .tick_ms_i    (tick_ms_i),
      .bus_data_o   (bus_data_o),
      .bus_rs_o     (bus_rs_o),
      .bus_wr_n_o   (bus_wr_n_o),
      .bus_cs_n_o   (bus_cs_n_o),
      .done_o       (done_o)
   );

   // ROM model: one cycle of read latency
   logic [7:0] mem [0:63];
   always @(posedge clk) begin
      if (rom_rd_o) rom_q <= mem[rom_addr_o[5:0]];
   end

   // tick source
   logic auto_tick = 1'b0;
   logic auto_pulse = 1'b0;
   logic man_tick = 1'b0;
   int   tdiv = 0;
   assign tick_ms_i = auto_tick ? auto_pulse : man_tick;
   always @(negedge clk) begin
      tdiv++;
      auto_pulse = ((tdiv % 4) == 0);
   end

   // bus monitor
   int         n_wr, lo_run, hi_run, bad_lo, bad_hi, bad_up, cs_bad, done_cnt, rd_cnt;
   logic [8:0] cap [0:63];
   logic       wr_prev = 1'b1;

   always @(negedge clk) begin
      if (!bus_wr_n_o) begin
         if (wr_prev && n_wr > 0 && hi_run < WR_HI_CYC) bad_hi++;
         lo_run++;
         if (bus_cs_n_o) cs_bad++;
      end else begin
         if (!wr_prev) begin
            if (lo_run != WR_LO_CYC) bad_lo++;
            if (bus_data_o[DATA_W-1:8] != '0) bad_up++;
            if (n_wr < 64) cap[n_wr] = {bus_rs_o, bus_data_o[7:0]};
            n_wr++;
            lo_run = 0;
            hi_run = 0;
         end
         hi_run++;
      end
      wr_prev = bus_wr_n_o;
      if (done_o) begin
         done_cnt++;
         if (!bus_cs_n_o) cs_bad++;
      end
      if (rom_rd_o) rd_cnt++;
   end

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_wr = 0; lo_run = 0; hi_run = 0; bad_lo = 0; bad_hi = 0;
      bad_up = 0; cs_bad = 0; done_cnt = 0; rd_cnt = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   // expected write list computed from the header rules
   logic [8:0] exp_wr [0:63];
   int         n_exp;

   task automatic build_expected(input int len);
      int pc;
      logic [7:0] h;
      pc = 0;
      n_exp = 0;
      while (pc < len) begin
         h = mem[pc]; pc++;
         if (h[6] && pc < len) begin exp_wr[n_exp] = {1'b0, mem[pc]}; n_exp++; pc++; end
         for (int k = 0; k < int'(h[5:0]) && pc < len; k++) begin
            exp_wr[n_exp] = {1'b1, mem[pc]}; n_exp++; pc++;
         end
         if (h[7] && pc < len) pc++;
      end
   endtask

   task automatic run_script(input int len, input string req);
      script_len_i = ADDR_W'(len);
      build_expected(len);
      clear_mon();
      pulse_start();
      for (int c = 0; c < 5000 && done_cnt == 0; c++) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(done_cnt == 1, "R9", {req, " done pulse count"}, done_cnt, 1);
      chk(n_wr == n_exp, req, "write count", n_wr, n_exp);
      for (int i = 0; i < n_exp && i < n_wr; i++)
         chk(cap[i] == exp_wr[i], req, $sformatf("write %0d {rs,byte}", i), cap[i], exp_wr[i]);
      chk(rd_cnt == len, "R8", {req, " rom reads"}, rd_cnt, len);
      chk(bad_lo == 0, "R4", {req, " strobe low width errors"}, bad_lo, 0);
      chk(bad_hi == 0, "R4", {req, " strobe high gap errors"}, bad_hi, 0);
      chk(bad_up == 0, "R4", {req, " nonzero upper bus bits"}, bad_up, 0);
      chk(cs_bad == 0, "R5", {req, " chip select violations"}, cs_bad, 0);
      chk(bus_cs_n_o == 1'b1, "R5", {req, " cs released after run"}, bus_cs_n_o, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(bus_cs_n_o == 1'b1, "R5", "reset cs_n", bus_cs_n_o, 1);
      chk(bus_wr_n_o == 1'b1, "R4", "reset wr_n", bus_wr_n_o, 1);
      chk(done_o == 1'b0, "R9", "reset done", done_o, 0);
      chk(rom_rd_o == 1'b0, "R8", "reset rom_rd", rom_rd_o, 0);
   endtask

   // R1 R2: flags with data, delay-only flag, zero delay
   task automatic t_mixed();
      mem[0] = 8'hC2; mem[1] = 8'h2A; mem[2] = 8'h00; mem[3] = 8'h10; mem[4] = 8'h02;
      mem[5] = 8'h83; mem[6] = 8'hAA; mem[7] = 8'h55; mem[8] = 8'hFF; mem[9] = 8'h00;
      mem[10] = 8'h40; mem[11] = 8'h2C;
      auto_tick = 1'b1;
      run_script(12, "R2");
      chk(n_wr == 7, "R1", "mixed script write total", n_wr, 7);
      chk(cap[0] == 9'h02A, "R1", "first write is command", cap[0], 9'h02A);
      auto_tick = 1'b0;
   endtask

   // R7: data-only, bare command, empty header
   task automatic t_shapes();
      mem[0] = 8'h03; mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33;
      mem[4] = 8'h40; mem[5] = 8'h29; mem[6] = 8'h00; mem[7] = 8'h01; mem[8] = 8'h44;
      run_script(9, "R7");
      chk(cap[3] == 9'h029, "R7", "bare command rs low", cap[3], 9'h029);
      chk(cap[4] == 9'h144, "R1", "write after empty header", cap[4], 9'h144);
   endtask

   // R3 R9: manual ticks, start ignored while stalled
   task automatic t_delay();
      mem[0] = 8'hC0; mem[1] = 8'h11; mem[2] = 8'h03; mem[3] = 8'h40; mem[4] = 8'h29;
      script_len_i = 8'd5;
      clear_mon();
      pulse_start();
      for (int c = 0; c < 200 && n_wr == 0; c++) @(negedge clk);
      repeat (60) @(negedge clk);
      chk(n_wr == 1, "R3", "writes before any tick", n_wr, 1);
      chk(done_cnt == 0, "R3", "done before any tick", done_cnt, 0);
      pulse_start();
      repeat (2) begin
         @(negedge clk); man_tick = 1'b1;
         @(negedge clk); man_tick = 1'b0;
         repeat (5) @(negedge clk);
      end
      repeat (40) @(negedge clk);
      chk(n_wr == 1, "R3", "writes after two ticks", n_wr, 1);
      @(negedge clk); man_tick = 1'b1;
      @(negedge clk); man_tick = 1'b0;
      repeat (60) @(negedge clk);
      chk(n_wr == 2, "R3", "writes after third tick", n_wr, 2);
      chk(cap[1] == 9'h029, "R2", "command after delay entry", cap[1], 9'h029);
      chk(done_cnt == 1, "R9", "done once with busy start", done_cnt, 1);
      repeat (100) @(negedge clk);
      chk(rd_cnt == 5, "R9", "no restart from busy start", rd_cnt, 5);
      chk(done_cnt == 1, "R9", "no second done", done_cnt, 1);
   endtask

   // R6: truncated entry, length shorter than stored bytes, empty script
   task automatic t_ends();
      mem[0] = 8'h43; mem[1] = 8'hB0; mem[2] = 8'h01; mem[3] = 8'h02; mem[4] = 8'h03;
      run_script(3, "R6");
      chk(n_wr == 2, "R6", "truncated entry writes", n_wr, 2);
      run_script(0, "R6");
      chk(n_wr == 0, "R6", "empty script writes", n_wr, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      start_i = 1'b0;
      script_len_i = '0;
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      clear_mon();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mixed();
      t_shapes();
      t_delay();
      t_ends();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule